// File: doc/BRIEF.md
# Trigger-Protected Circular Cell Addresser

This block generates the addresses for a ring of sample cells that is written once per clock. A write pointer visits the cells in ascending order and wraps from the last cell back to cell 0. When a trigger arrives, the block looks up the cell that was written a programmable number of clocks earlier and locks it, together with the two cells written in the two clocks after it. The addresses of these three cells go into an index FIFO in write order. A locked cell is left out of the write sequence, so its content survives until readout. The stored sample values are outside this block. It handles only the addresses.

A readout agent pulses a pop request. The block then returns the oldest locked address, clears that cell's lock and frees its FIFO slot. A trigger is refused, and an error pulse is raised, in four cases: the latency setting is outside its legal window, the ring has not yet been written for that many clocks since reset, the index FIFO lacks room for three addresses, or a target cell is still locked from an earlier trigger. A refused trigger locks nothing.

Top module: `sbuf_trig_ring`

## Requirements
- R1: While reset is held, and after it is released, `wr_cell` is 0 and `rd_valid` and `trig_err` are 0.
- R2: `wr_cell` changes on every clock edge to the next unlocked cell index in ascending order, counted modulo 192 (cell 191 is followed by cell 0).
- R3: An accepted trigger with latency L locks the cells that `wr_cell` showed L, L-1 and L-2 cycles before the trigger cycle. The write pointer skips these cells from then on.
- R4: A pop request with the index FIFO non-empty sets `rd_valid` one cycle later, with `rd_cell` holding the oldest locked address. Addresses come out in trigger order, and the three cells of one trigger come out in their write order.
- R5: A popped cell is unlocked, and the write pointer visits it again on its next pass.
- R6: A pop request while the index FIFO is empty is ignored, and `rd_valid` stays 0 in the next cycle.
- R7: The index FIFO holds 32 addresses. A trigger that finds fewer than 3 free slots raises `trig_err` for one cycle, one cycle later, and locks nothing.
- R8: A latency below 3 or above 160 refuses the trigger, with `trig_err` and no lock. Latencies 3 to 160 inclusive are legal.
- R9: A trigger arriving before L write cycles have passed since reset is refused, with `trig_err` and no lock.
- R10: A trigger whose target cells include a cell that is already locked is refused, with `trig_err` and no lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Trigger symbol, one cycle |
| cfg_latency | input | 8 | Trigger latency in write cycles (3..160) |
| rd_pop | input | 1 | Pop the oldest locked address |
| wr_cell | output | 8 | Cell written in this cycle |
| trig_err | output | 1 | Refused-trigger pulse |
| rd_valid | output | 1 | `rd_cell` holds a popped address |
| rd_cell | output | 8 | Popped cell address |

## Verification
`wr_cell` moves at every rising edge. `trig_err`, `rd_valid` and `rd_cell` answer the inputs of a cycle one edge later. Each step of the bench drives its inputs at a falling edge and updates a reference model for the coming rising edge. It then waits for that edge and compares every output at the following falling edge, which is exactly when the registered results are due. Popped addresses are queued by the driver when the pop is issued, and a monitor matches them on the falling edge after `rd_valid` rises.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  // Outcome of a trigger request, in order of check priority
  typedef enum logic [2:0] {
    TV_OK,
    TV_BAD_LAT,
    TV_SHORT_HIST,
    TV_FIFO_FULL,
    TV_OVERLAP
  } trig_verdict_e;
endpackage

// File: rtl/sbuf_wptr.sv
// Lock bitmap and write pointer that steps over locked cells.
module sbuf_wptr #(
  parameter int N_CELLS = 192,
  parameter int NLOCK   = 3,
  parameter int CW      = $clog2(N_CELLS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      set_en,
  input  logic [NLOCK-1:0][CW-1:0]  set_cells,
  input  logic                      clr_en,
  input  logic [CW-1:0]             clr_cell,
  output logic [CW-1:0]             wr_cell,
  output logic [N_CELLS-1:0]        lock_vec
);
  logic [CW-1:0]      wr_q, wr_nxt;
  logic [N_CELLS-1:0] lock_q;
  logic               found;
  int                 idx;

  // first unlocked cell after the current one, wrapping
  always_comb begin
    wr_nxt = wr_q;
    found  = 1'b0;
    idx    = 0;
    for (int k = 1; k <= N_CELLS; k++) begin
      idx = int'(wr_q) + k;
      if (idx >= N_CELLS) idx = idx - N_CELLS;
      if (!found && !lock_q[idx]) begin
        wr_nxt = CW'(idx);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= '0;
      lock_q <= '0;
    end else begin
      wr_q <= wr_nxt;
      if (clr_en) lock_q[clr_cell] <= 1'b0;
      if (set_en)
        for (int k = 0; k < NLOCK; k++) lock_q[set_cells[k]] <= 1'b1;
    end
  end

  assign wr_cell  = wr_q;
  assign lock_vec = lock_q;

  p_write_unlocked_r2: assert property (@(posedge clk) disable iff (rst)
    !lock_q[wr_q]);
  p_ptr_range_r2: assert property (@(posedge clk) disable iff (rst)
    wr_q < CW'(N_CELLS));
  p_set_not_locked_r10: assert property (@(posedge clk) disable iff (rst)
    set_en |-> !lock_q[set_cells[0]] && !lock_q[set_cells[NLOCK-1]]);
  p_set_takes_r3: assert property (@(posedge clk) disable iff (rst)
    set_en |=> lock_q[$past(set_cells[0])]);
endmodule

// File: rtl/sbuf_history.sv
// Ring of recently written cell indices, tapped at the programmed latency.
module sbuf_history #(
  parameter int LAT_MAX = 160,
  parameter int NTAP    = 3,
  parameter int CW      = 8,
  parameter int HW      = $clog2(LAT_MAX + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CW-1:0]            wr_cell,
  input  logic [HW-1:0]            latency,
  output logic [NTAP-1:0][CW-1:0]  tap,
  output logic                     hist_ok
);
  localparam int DEPTH = 1 << HW;

  logic [CW-1:0] mem [DEPTH];
  logic [HW-1:0] hp;
  logic [HW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hp  <= '0;
      cnt <= '0;
    end else begin
      hp <= hp + 1'b1;
      if (cnt < HW'(LAT_MAX)) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) mem[hp] <= wr_cell;

  generate
    for (genvar g = 0; g < NTAP; g++) begin : g_tap
      assign tap[g] = mem[hp - latency + HW'(g)];
    end
  endgenerate

  assign hist_ok = (cnt >= latency);

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cnt <= HW'(LAT_MAX));
endmodule

// File: rtl/sbuf_index_fifo.sv
// Index FIFO: several pushes per cycle, one pop per cycle.
module sbuf_index_fifo #(
  parameter int DEPTH = 32,
  parameter int NPUSH = 3,
  parameter int CW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push_en,
  input  logic [NPUSH-1:0][CW-1:0]  push_cells,
  input  logic                      pop_en,
  output logic [CW-1:0]             head,
  output logic                      empty,
  output logic [AW:0]               count,
  output logic [AW:0]               free
);
  logic [CW-1:0] mem [DEPTH];
  logic [AW:0]   wp, rp;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push_en) wp <= wp + (AW+1)'(NPUSH);
      if (pop_en)  rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (push_en)
      for (int k = 0; k < NPUSH; k++) mem[wp[AW-1:0] + AW'(k)] <= push_cells[k];

  assign head  = mem[rp[AW-1:0]];
  assign count = wp - rp;
  assign empty = (count == '0);
  assign free  = (AW+1)'(DEPTH) - count;

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));
  p_push_room_r7: assert property (@(posedge clk) disable iff (rst)
    push_en |-> free >= (AW+1)'(NPUSH));
  p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (rst)
    pop_en |-> !empty);
endmodule

// File: rtl/sbuf_trig_ring.sv
module sbuf_trig_ring
  import sbuf_pkg::*;
#(
  parameter int N_CELLS    = 192,
  parameter int FIFO_DEPTH = 32,
  parameter int NLOCK      = 3,
  parameter int LAT_MAX    = 160,
  parameter int CW         = $clog2(N_CELLS),
  parameter int LW         = $clog2(LAT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig,
  input  logic [LW-1:0] cfg_latency,
  input  logic          rd_pop,
  output logic [CW-1:0] wr_cell,
  output logic          trig_err,
  output logic          rd_valid,
  output logic [CW-1:0] rd_cell
);
  localparam int LAT_MIN = NLOCK;
  localparam int AW      = $clog2(FIFO_DEPTH);

  logic [NLOCK-1:0][CW-1:0] tap;
  logic                     hist_ok;
  logic [N_CELLS-1:0]       lock_vec;
  logic [CW-1:0]            head;
  logic                     empty;
  logic [AW:0]              count, free;
  logic                     overlap, push_en, pop_en;
  trig_verdict_e            verdict;

  sbuf_wptr #(.N_CELLS(N_CELLS), .NLOCK(NLOCK), .CW(CW)) u_wptr (
    .clk(clk), .rst(rst),
    .set_en(push_en), .set_cells(tap),
    .clr_en(pop_en), .clr_cell(head),
    .wr_cell(wr_cell), .lock_vec(lock_vec)
  );

  sbuf_history #(.LAT_MAX(LAT_MAX), .NTAP(NLOCK), .CW(CW), .HW(LW)) u_hist (
    .clk(clk), .rst(rst), .wr_cell(wr_cell), .latency(cfg_latency),
    .tap(tap), .hist_ok(hist_ok)
  );

  sbuf_index_fifo #(.DEPTH(FIFO_DEPTH), .NPUSH(NLOCK), .CW(CW), .AW(AW)) u_fifo (
    .clk(clk), .rst(rst),
    .push_en(push_en), .push_cells(tap), .pop_en(pop_en),
    .head(head), .empty(empty), .count(count), .free(free)
  );

  always_comb begin
    overlap = 1'b0;
    for (int k = 0; k < NLOCK; k++) overlap = overlap | lock_vec[tap[k]];
  end

  always_comb begin
    if (cfg_latency < LW'(LAT_MIN) || cfg_latency > LW'(LAT_MAX)) verdict = TV_BAD_LAT;
    else if (!hist_ok)                    verdict = TV_SHORT_HIST;
    else if (free < (AW+1)'(NLOCK))       verdict = TV_FIFO_FULL;
    else if (overlap)                     verdict = TV_OVERLAP;
    else                                  verdict = TV_OK;
  end

  assign push_en = trig && (verdict == TV_OK);
  assign pop_en  = rd_pop && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_err <= 1'b0;
      rd_valid <= 1'b0;
      rd_cell  <= '0;
    end else begin
      trig_err <= trig && (verdict != TV_OK);
      rd_valid <= pop_en;
      if (pop_en) rd_cell <= head;
    end
  end

  p_locks_match_fifo_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(lock_vec) == int'(count));
  p_pop_unlocks_r5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !lock_vec[rd_cell]);
  p_empty_pop_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_pop && empty) |=> !rd_valid);
  p_err_no_lock_r7: assert property (@(posedge clk) disable iff (rst)
    trig_err |-> int'(count) == int'($past(count)) - int'($past(pop_en)));
endmodule

// File: tb/sbuf_trig_ring_tb.sv
module sbuf_trig_ring_tb;
  localparam int NC = 192;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       trig = 1'b0;
  logic [7:0] cfg_latency = 8'd10;
  logic       rd_pop = 1'b0;
  logic [7:0] wr_cell, rd_cell;
  logic       trig_err, rd_valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference model
  int       m_w;
  bit       m_lock [NC];
  int       m_hist [$];
  int       m_fifo [$];
  bit       m_err, m_rdv;
  int       exp_q  [$];

  always #5 clk = ~clk;

  sbuf_trig_ring u_dut (
    .clk(clk), .rst(rst), .trig(trig), .cfg_latency(cfg_latency),
    .rd_pop(rd_pop), .wr_cell(wr_cell), .trig_err(trig_err),
    .rd_valid(rd_valid), .rd_cell(rd_cell)
  );

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // model of one rising edge for the current inputs
  task automatic model_edge(bit t, bit p, int lat);
    int  c [3];
    bit  acc = 1'b0;
    int  nxt = m_w;
    int  popped = -1;
    m_err = 1'b0;
    if (t) begin
      if (lat < 3 || lat > 160)        m_err = 1'b1;
      else if (m_hist.size() < lat)    m_err = 1'b1;
      else if (32 - m_fifo.size() < 3) m_err = 1'b1;
      else begin
        for (int k = 0; k < 3; k++) c[k] = m_hist[m_hist.size() - lat + k];
        if (m_lock[c[0]] || m_lock[c[1]] || m_lock[c[2]]) m_err = 1'b1;
        else acc = 1'b1;
      end
    end
    m_rdv = 1'b0;
    if (p && m_fifo.size() > 0) begin
      popped = m_fifo.pop_front();
      exp_q.push_back(popped);
      m_rdv = 1'b1;
    end
    for (int k = 1; k <= NC; k++) begin
      int i = (m_w + k) % NC;
      if (!m_lock[i]) begin nxt = i; break; end
    end
    m_hist.push_back(m_w);
    if (m_hist.size() > 200) void'(m_hist.pop_front());
    if (acc) for (int k = 0; k < 3; k++) begin
      m_lock[c[k]] = 1'b1;
      m_fifo.push_back(c[k]);
    end
    if (popped >= 0) m_lock[popped] = 1'b0;
    m_w = nxt;
  endtask

  // driver: one cycle with the given inputs, then check the registered results
  task automatic step(bit t, bit p, string tag);
    trig = t;
    rd_pop = p;
    model_edge(t, p, int'(cfg_latency));
    @(posedge clk);
    @(negedge clk);
    trig = 1'b0;
    rd_pop = 1'b0;
    check("R2 R3 R5 wr_cell", int'(wr_cell), m_w);
    check({tag, " trig_err"}, int'(trig_err), int'(m_err));
    check("R6 rd_valid", int'(rd_valid), int'(m_rdv));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, "R2");
  endtask

  // monitor: compare popped addresses against the scoreboard
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_tests++;
        n_fail++;
        $display("FAIL R4: actual rd_cell %0d expected no pop", rd_cell);
      end else begin
        check("R4 rd_cell", int'(rd_cell), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_w = 0;
    m_err = 0;
    m_rdv = 0;
    for (int i = 0; i < NC; i++) m_lock[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 wr_cell", int'(wr_cell), 0);
    check("R1 rd_valid", int'(rd_valid), 0);
    check("R1 trig_err", int'(trig_err), 0);
    rst = 1'b0;

    // R9: trigger before enough history exists
    cfg_latency = 8'd10;
    idle(4);
    step(1'b1, 1'b0, "R9");
    idle(8);
    // R8: latency outside the legal window
    cfg_latency = 8'd2;
    step(1'b1, 1'b0, "R8 low");
    cfg_latency = 8'd161;
    step(1'b1, 1'b0, "R8 high");
    // R2: run past the wrap
    idle(200);

    // R3 accepted, then R10 overlapping trigger
    cfg_latency = 8'd20;
    step(1'b1, 1'b0, "R3");
    step(1'b1, 1'b0, "R10");
    idle(200);
    // R4 pop in order, R6 pop on empty, R5 cells return
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R4");
    step(1'b0, 1'b1, "R6");
    idle(200);

    // R7 fill the index FIFO at the top legal latency (R8 boundary)
    cfg_latency = 8'd160;
    for (int i = 0; i < 10; i++) begin
      step(1'b1, 1'b0, "R8 max");
      idle(3);
    end
    step(1'b1, 1'b0, "R7");
    idle(200);
    // pop while triggering: pop frees one slot, still too few for R7
    step(1'b1, 1'b1, "R7 pop");
    for (int i = 0; i < 31; i++) step(1'b0, 1'b1, "R4");
    step(1'b0, 1'b1, "R6");
    idle(200);

    check("R4 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule